// File: doc/BRIEF.md
# RISC Instruction Decoder

This block takes one 32-bit instruction word and the address it was fetched from, and returns a registered bundle of control signals for a 32-register RISC core. The signals cover the source register indices, the destination register and its write enable, an ALU operation code, an immediate operand, the memory access kind, width, signedness and I/O bypass, a control-flow kind, a computed jump or branch target, the return-link value, and an exception request. A valid strobe goes with each word. The register file, the datapath, memory and the pipeline control sit outside the block.

Words come in three layouts. The low six bits always hold the primary opcode. One primary value escapes to a second table that is indexed by a six-bit extended opcode in bits [16:11]. Field positions follow a fixed map: A in [31:27], B in [26:22], C in [21:17], a 5-bit immediate in [10:6], a 16-bit immediate in [21:6] and a 26-bit immediate in [31:6]. Decoding is combinational. The result is registered once for each accepted word and is held when no word arrives.

Top module: `risc_insn_decode`

## Requirements
- R1: Outputs change only on the clock edge at which valid_i is high, and then reflect that word. valid_o is high for exactly the cycle after an accepted word. While valid_i is low every other output holds its value. After reset every output is zero.
- R2: ra_idx_o carries bits [31:27] and rb_idx_o carries bits [26:22]. The exceptions are three register-return forms: extended 0x05 gives A index 31, extended 0x09 gives A index 30, and extended 0x01 gives A index 29. The destination is B for immediate-format operations and loads, and C for register-format operations.
- R3: imm_o and use_imm_o. Add-immediate 0x04, multiply-immediate 0x24, the signed compare-immediates (0x08, 0x10, 0x18, 0x20) and all load/store offsets sign-extend bits [21:6]. AND/OR/XOR-immediate (0x0C, 0x14, 0x1C) and the unsigned compares (0x28, 0x30) zero-extend them. The high forms 0x2C, 0x34 and 0x3C place them in bits [31:16]. Shift/rotate-immediate and control-register operations use bits [10:6], zero-extended. imm_o is 0 when use_imm_o is low.
- R4: alu_op_o encoding: 0 none, 1 add, 2 sub, 3 mul, 4 and, 5 or, 6 xor, 7 nor, 8 sll, 9 srl, 10 sra, 11 rol, 12 ror, 13 eq, 14 ne, 15 lt, 16 ge, 17 ltu, 18 geu, 19 mul-high signed*signed, 20 unsigned*unsigned, 21 signed*unsigned, 22 signed divide, 23 unsigned divide, 24 link, 25 control read, 26 control write. Examples: extended 0x31 is add, 0x39 is sub, 0x3A is sra with imm5, and 0x24 is unsigned divide.
- R5: Load opcodes 0x03/0x07 (byte), 0x0B/0x0F (half) and 0x17 (word) use mem_size_o 0/1/2, with mem_signed_o set for 0x07 and 0x0F. The forms 0x23, 0x27, 0x2B, 0x2F and 0x37 behave the same but also set mem_bypass_o. Stores are 0x05, 0x0D and 0x15, with bypass forms 0x25, 0x2D and 0x35. Loads and stores use alu add for the address. A load whose destination is register 0 still raises mem_rd_o.
- R6: rd_we_o is never high with rd_idx_o equal to 0. Any write aimed at register 0 is dropped, and rd_idx_o reads 0 for it.
- R7: flow_o encoding: 0 none, 1 unconditional, 2 eq, 3 ne, 4 lt, 5 ge, 6 ltu, 7 geu, 8 jump to register A, 9 exception return. For 0x06 (always), 0x26 (eq), 0x1E (ne), 0x16 (lt), 0x0E (ge), 0x36 (ltu) and 0x2E (geu), target_o = pc+4 + (sign-extended bits [21:6] with bits [1:0] cleared).
- R8: For 0x01 (jump) and 0x00 (call), target_o is pc bits [31:28] joined with bits [31:6] and two zero bits, and flow_o is 1. For all other operations target_o is 0.
- R9: link_o always equals pc+4. Call 0x00 and register call (extended 0x1D) write register 31 with alu_op 24. Extended 0x1C writes register C with alu_op 24.
- R10: exc_o encoding: 0 none, 1 illegal, 2 unimplemented, 3 trap (extended 0x2D), 4 breakpoint (extended 0x34). Primary 0x32 and 0x38 and extended 0x14 are unimplemented. Every unassigned primary slot (for example 0x02) and every unassigned extended slot, including all above 0x3B, are illegal. When exc_o is nonzero, no register write, memory access or control flow is signalled.
- R11: Cache-maintenance and no-op slots (primary 0x13, 0x1B, 0x33, 0x3B; extended 0x04, 0x0C, 0x29, 0x36) produce all-zero control outputs and no exception.
- R12: Control-register read (extended 0x26) writes register C with alu_op 25 and the register number in imm_o. Control-register write (extended 0x2E) gives alu_op 26, the number in imm_o, and no register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Instruction word present |
| insn_i | input | 32 | Instruction word |
| pc_i | input | 32 | Address of the instruction |
| valid_o | output | 1 | Decoded bundle updated this cycle |
| ra_idx_o | output | 5 | Source register A index |
| rb_idx_o | output | 5 | Source register B index |
| rd_idx_o | output | 5 | Destination register index |
| rd_we_o | output | 1 | Destination write enable |
| alu_op_o | output | 5 | ALU operation code |
| imm_o | output | 32 | Immediate operand |
| use_imm_o | output | 1 | Immediate replaces operand B |
| mem_rd_o | output | 1 | Memory load |
| mem_wr_o | output | 1 | Memory store |
| mem_size_o | output | 2 | Access width: 0 byte, 1 half, 2 word |
| mem_signed_o | output | 1 | Sign-extend loaded data |
| mem_bypass_o | output | 1 | Access bypasses the data cache |
| flow_o | output | 4 | Control-flow kind |
| target_o | output | 32 | Computed branch or jump target |
| link_o | output | 32 | Return address pc+4 |
| exc_o | output | 3 | Exception request |

## Verification
The bench targets these corner cases:
- A negative branch offset whose low bits are nonzero. A design that skipped the masking, or added the offset to pc instead of pc+4, would be off by a few bytes.
- An absolute jump from a pc with high bits set. A design that dropped or shifted the page bits would jump into the wrong region.
- A load aimed at register 0. A decoder that suppressed the whole operation would lose the memory read; one that forgot suppression would assert a write to register 0.
- Slots just past the end of the extended table, unassigned slots between assigned ones, and the unimplemented slots. Each must give its own exception code and be kept apart from the quiet cache no-ops.
- Holding the outputs through idle cycles while garbage sits on insn_i, which catches a decoder that loads its registers without looking at valid_i.

// File: rtl/rdec_pkg.sv
package rdec_pkg;
  localparam int unsigned INSN_W = 32;
  localparam int unsigned REG_AW = 5;
  localparam int unsigned OP_W   = 6;

  typedef enum logic [4:0] {
    ALU_NONE = 5'd0,  ALU_ADD = 5'd1,  ALU_SUB = 5'd2,  ALU_MUL = 5'd3,
    ALU_AND  = 5'd4,  ALU_OR  = 5'd5,  ALU_XOR = 5'd6,  ALU_NOR = 5'd7,
    ALU_SLL  = 5'd8,  ALU_SRL = 5'd9,  ALU_SRA = 5'd10, ALU_ROL = 5'd11,
    ALU_ROR  = 5'd12, ALU_EQ  = 5'd13, ALU_NE  = 5'd14, ALU_LT  = 5'd15,
    ALU_GE   = 5'd16, ALU_LTU = 5'd17, ALU_GEU = 5'd18,
    ALU_MHSS = 5'd19, ALU_MHUU = 5'd20, ALU_MHSU = 5'd21,
    ALU_DIVS = 5'd22, ALU_DIVU = 5'd23, ALU_LINK = 5'd24,
    ALU_CTRD = 5'd25, ALU_CTWR = 5'd26
  } alu_op_e;

  typedef enum logic [3:0] {
    FL_NONE = 4'd0, FL_ALWAYS = 4'd1, FL_EQ = 4'd2, FL_NE = 4'd3,
    FL_LT   = 4'd4, FL_GE     = 4'd5, FL_LTU = 4'd6, FL_GEU = 4'd7,
    FL_REG  = 4'd8, FL_XRET   = 4'd9
  } flow_e;

  typedef enum logic [2:0] {
    EXC_NONE = 3'd0, EXC_ILLEGAL = 3'd1, EXC_UNIMPL = 3'd2,
    EXC_TRAP = 3'd3, EXC_BREAK = 3'd4
  } exc_e;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} msize_e;
  typedef enum logic [2:0] {IMM_NONE, IMM_SEXT, IMM_ZEXT, IMM_HIGH, IMM_U5} imm_sel_e;
  typedef enum logic [1:0] {DST_NONE, DST_B, DST_C, DST_LINK} dst_e;
  typedef enum logic [1:0] {ASEL_FIELD, ASEL_RA, ASEL_BA, ASEL_EA} asel_e;
  typedef enum logic [1:0] {TGT_NONE, TGT_REL, TGT_ABS} tgt_e;

  typedef struct packed {
    alu_op_e  alu;
    imm_sel_e imm_sel;
    dst_e     dst;
    asel_e    asel;
    tgt_e     tgt;
    flow_e    flow;
    exc_e     exc;
    logic     mem_rd;
    logic     mem_wr;
    msize_e   size;
    logic     msigned;
    logic     bypass;
  } ctl_t;

  function automatic ctl_t ctl_nop();
    ctl_t t;
    t = '0;
    return t;
  endfunction

  function automatic ctl_t ctl_exc(exc_e e);
    ctl_t t;
    t = '0;
    t.exc = e;
    return t;
  endfunction

  function automatic ctl_t ctl_alu(alu_op_e op, imm_sel_e s, dst_e d);
    ctl_t t;
    t = '0;
    t.alu = op;
    t.imm_sel = s;
    t.dst = d;
    return t;
  endfunction

  function automatic ctl_t ctl_mem(logic wr, msize_e sz, logic sg, logic bp);
    ctl_t t;
    t = ctl_alu(ALU_ADD, IMM_SEXT, wr ? DST_NONE : DST_B);
    t.mem_rd  = ~wr;
    t.mem_wr  = wr;
    t.size    = sz;
    t.msigned = sg;
    t.bypass  = bp;
    return t;
  endfunction

  function automatic ctl_t ctl_br(flow_e f);
    ctl_t t;
    t = '0;
    t.flow = f;
    t.tgt  = TGT_REL;
    return t;
  endfunction

  function automatic ctl_t ctl_jr(flow_e f, asel_e a);
    ctl_t t;
    t = '0;
    t.flow = f;
    t.asel = a;
    return t;
  endfunction
endpackage

// File: rtl/rdec_fields.sv
module rdec_fields
  import rdec_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  input  imm_sel_e          imm_sel_i,
  output logic [OP_W-1:0]   op_o,
  output logic [OP_W-1:0]   opx_o,
  output logic [REG_AW-1:0] a_o,
  output logic [REG_AW-1:0] b_o,
  output logic [REG_AW-1:0] c_o,
  output logic [15:0]       imm16_o,
  output logic [25:0]       imm26_o,
  output logic [INSN_W-1:0] imm_o
);
  logic [4:0] imm5;

  assign op_o    = insn_i[5:0];
  assign imm5    = insn_i[10:6];
  assign opx_o   = insn_i[16:11];
  assign c_o     = insn_i[21:17];
  assign b_o     = insn_i[26:22];
  assign a_o     = insn_i[31:27];
  assign imm16_o = insn_i[21:6];
  assign imm26_o = insn_i[31:6];

  always_comb begin
    unique case (imm_sel_i)
      IMM_SEXT: imm_o = {{16{imm16_o[15]}}, imm16_o};
      IMM_ZEXT: imm_o = {16'h0, imm16_o};
      IMM_HIGH: imm_o = {imm16_o, 16'h0};
      IMM_U5:   imm_o = {27'h0, imm5};
      default:  imm_o = '0;
    endcase
  end
endmodule

// File: rtl/rdec_primary.sv
module rdec_primary
  import rdec_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output logic            rtype_o,
  output ctl_t            ctl_o
);
  always_comb begin
    rtype_o = 1'b0;
    ctl_o   = ctl_exc(EXC_ILLEGAL);
    unique case (op_i)
      6'h00: begin
        ctl_o = ctl_br(FL_ALWAYS);
        ctl_o.tgt = TGT_ABS;
        ctl_o.alu = ALU_LINK;
        ctl_o.dst = DST_LINK;
      end
      6'h01: begin
        ctl_o = ctl_br(FL_ALWAYS);
        ctl_o.tgt = TGT_ABS;
      end
      6'h06: ctl_o = ctl_br(FL_ALWAYS);
      6'h26: ctl_o = ctl_br(FL_EQ);
      6'h1E: ctl_o = ctl_br(FL_NE);
      6'h16: ctl_o = ctl_br(FL_LT);
      6'h0E: ctl_o = ctl_br(FL_GE);
      6'h36: ctl_o = ctl_br(FL_LTU);
      6'h2E: ctl_o = ctl_br(FL_GEU);
      // loads: plain and cache-bypass forms
      6'h03: ctl_o = ctl_mem(1'b0, SZ_BYTE, 1'b0, 1'b0);
      6'h07: ctl_o = ctl_mem(1'b0, SZ_BYTE, 1'b1, 1'b0);
      6'h0B: ctl_o = ctl_mem(1'b0, SZ_HALF, 1'b0, 1'b0);
      6'h0F: ctl_o = ctl_mem(1'b0, SZ_HALF, 1'b1, 1'b0);
      6'h17: ctl_o = ctl_mem(1'b0, SZ_WORD, 1'b0, 1'b0);
      6'h23: ctl_o = ctl_mem(1'b0, SZ_BYTE, 1'b0, 1'b1);
      6'h27: ctl_o = ctl_mem(1'b0, SZ_BYTE, 1'b1, 1'b1);
      6'h2B: ctl_o = ctl_mem(1'b0, SZ_HALF, 1'b0, 1'b1);
      6'h2F: ctl_o = ctl_mem(1'b0, SZ_HALF, 1'b1, 1'b1);
      6'h37: ctl_o = ctl_mem(1'b0, SZ_WORD, 1'b0, 1'b1);
      // stores
      6'h05: ctl_o = ctl_mem(1'b1, SZ_BYTE, 1'b0, 1'b0);
      6'h0D: ctl_o = ctl_mem(1'b1, SZ_HALF, 1'b0, 1'b0);
      6'h15: ctl_o = ctl_mem(1'b1, SZ_WORD, 1'b0, 1'b0);
      6'h25: ctl_o = ctl_mem(1'b1, SZ_BYTE, 1'b0, 1'b1);
      6'h2D: ctl_o = ctl_mem(1'b1, SZ_HALF, 1'b0, 1'b1);
      6'h35: ctl_o = ctl_mem(1'b1, SZ_WORD, 1'b0, 1'b1);
      // arithmetic / logic with immediate
      6'h04: ctl_o = ctl_alu(ALU_ADD, IMM_SEXT, DST_B);
      6'h24: ctl_o = ctl_alu(ALU_MUL, IMM_SEXT, DST_B);
      6'h0C: ctl_o = ctl_alu(ALU_AND, IMM_ZEXT, DST_B);
      6'h14: ctl_o = ctl_alu(ALU_OR,  IMM_ZEXT, DST_B);
      6'h1C: ctl_o = ctl_alu(ALU_XOR, IMM_ZEXT, DST_B);
      6'h2C: ctl_o = ctl_alu(ALU_AND, IMM_HIGH, DST_B);
      6'h34: ctl_o = ctl_alu(ALU_OR,  IMM_HIGH, DST_B);
      6'h3C: ctl_o = ctl_alu(ALU_XOR, IMM_HIGH, DST_B);
      6'h08: ctl_o = ctl_alu(ALU_GE,  IMM_SEXT, DST_B);
      6'h10: ctl_o = ctl_alu(ALU_LT,  IMM_SEXT, DST_B);
      6'h18: ctl_o = ctl_alu(ALU_NE,  IMM_SEXT, DST_B);
      6'h20: ctl_o = ctl_alu(ALU_EQ,  IMM_SEXT, DST_B);
      6'h28: ctl_o = ctl_alu(ALU_GEU, IMM_ZEXT, DST_B);
      6'h30: ctl_o = ctl_alu(ALU_LTU, IMM_ZEXT, DST_B);
      // cache maintenance: no effect
      6'h13, 6'h1B, 6'h33, 6'h3B: ctl_o = ctl_nop();
      6'h32, 6'h38: ctl_o = ctl_exc(EXC_UNIMPL);
      6'h3A: begin
        rtype_o = 1'b1;
        ctl_o   = ctl_nop();
      end
      default: ctl_o = ctl_exc(EXC_ILLEGAL);
    endcase
  end
endmodule

// File: rtl/rdec_ext.sv
module rdec_ext
  import rdec_pkg::*;
(
  input  logic [OP_W-1:0] opx_i,
  output ctl_t            ctl_o
);
  always_comb begin
    ctl_o = ctl_exc(EXC_ILLEGAL);
    unique case (opx_i)
      6'h01: ctl_o = ctl_jr(FL_XRET, ASEL_EA);
      6'h05: ctl_o = ctl_jr(FL_REG, ASEL_RA);
      6'h09: ctl_o = ctl_jr(FL_REG, ASEL_BA);
      6'h0D: ctl_o = ctl_jr(FL_REG, ASEL_FIELD);
      6'h1D: begin
        ctl_o = ctl_jr(FL_REG, ASEL_FIELD);
        ctl_o.alu = ALU_LINK;
        ctl_o.dst = DST_LINK;
      end
      6'h1C: ctl_o = ctl_alu(ALU_LINK, IMM_NONE, DST_C);
      6'h02: ctl_o = ctl_alu(ALU_ROL,  IMM_U5,   DST_C);
      6'h03: ctl_o = ctl_alu(ALU_ROL,  IMM_NONE, DST_C);
      6'h0B: ctl_o = ctl_alu(ALU_ROR,  IMM_NONE, DST_C);
      6'h12: ctl_o = ctl_alu(ALU_SLL,  IMM_U5,   DST_C);
      6'h13: ctl_o = ctl_alu(ALU_SLL,  IMM_NONE, DST_C);
      6'h1A: ctl_o = ctl_alu(ALU_SRL,  IMM_U5,   DST_C);
      6'h1B: ctl_o = ctl_alu(ALU_SRL,  IMM_NONE, DST_C);
      6'h3A: ctl_o = ctl_alu(ALU_SRA,  IMM_U5,   DST_C);
      6'h3B: ctl_o = ctl_alu(ALU_SRA,  IMM_NONE, DST_C);
      6'h06: ctl_o = ctl_alu(ALU_NOR,  IMM_NONE, DST_C);
      6'h0E: ctl_o = ctl_alu(ALU_AND,  IMM_NONE, DST_C);
      6'h16: ctl_o = ctl_alu(ALU_OR,   IMM_NONE, DST_C);
      6'h1E: ctl_o = ctl_alu(ALU_XOR,  IMM_NONE, DST_C);
      6'h31: ctl_o = ctl_alu(ALU_ADD,  IMM_NONE, DST_C);
      6'h39: ctl_o = ctl_alu(ALU_SUB,  IMM_NONE, DST_C);
      6'h27: ctl_o = ctl_alu(ALU_MUL,  IMM_NONE, DST_C);
      6'h1F: ctl_o = ctl_alu(ALU_MHSS, IMM_NONE, DST_C);
      6'h07: ctl_o = ctl_alu(ALU_MHUU, IMM_NONE, DST_C);
      6'h17: ctl_o = ctl_alu(ALU_MHSU, IMM_NONE, DST_C);
      6'h25: ctl_o = ctl_alu(ALU_DIVS, IMM_NONE, DST_C);
      6'h24: ctl_o = ctl_alu(ALU_DIVU, IMM_NONE, DST_C);
      6'h20: ctl_o = ctl_alu(ALU_EQ,   IMM_NONE, DST_C);
      6'h18: ctl_o = ctl_alu(ALU_NE,   IMM_NONE, DST_C);
      6'h10: ctl_o = ctl_alu(ALU_LT,   IMM_NONE, DST_C);
      6'h08: ctl_o = ctl_alu(ALU_GE,   IMM_NONE, DST_C);
      6'h30: ctl_o = ctl_alu(ALU_LTU,  IMM_NONE, DST_C);
      6'h28: ctl_o = ctl_alu(ALU_GEU,  IMM_NONE, DST_C);
      6'h26: ctl_o = ctl_alu(ALU_CTRD, IMM_U5,   DST_C);
      6'h2E: ctl_o = ctl_alu(ALU_CTWR, IMM_U5,   DST_NONE);
      6'h2D: ctl_o = ctl_exc(EXC_TRAP);
      6'h34: ctl_o = ctl_exc(EXC_BREAK);
      6'h14: ctl_o = ctl_exc(EXC_UNIMPL);
      6'h04, 6'h0C, 6'h29, 6'h36: ctl_o = ctl_nop();
      default: ctl_o = ctl_exc(EXC_ILLEGAL);
    endcase
  end
endmodule

// File: rtl/rdec_target.sv
module rdec_target
  import rdec_pkg::*;
(
  input  logic [INSN_W-1:0] pc_i,
  input  logic [15:0]       imm16_i,
  input  logic [25:0]       imm26_i,
  input  tgt_e              tgt_i,
  output logic [INSN_W-1:0] target_o,
  output logic [INSN_W-1:0] link_o
);
  localparam int unsigned PAGE_W = INSN_W - 28;
  logic [INSN_W-1:0] rel_off;

  assign link_o  = pc_i + INSN_W'(4);
  assign rel_off = {{(INSN_W-16){imm16_i[15]}}, imm16_i[15:2], 2'b00};

  always_comb begin
    unique case (tgt_i)
      TGT_REL: target_o = link_o + rel_off;
      TGT_ABS: target_o = {pc_i[INSN_W-1 -: PAGE_W], imm26_i, 2'b00};
      default: target_o = '0;
    endcase
  end
endmodule

// File: rtl/risc_insn_decode.sv
module risc_insn_decode
  import rdec_pkg::*;
#(
  parameter int unsigned LINK_IDX = 31,
  parameter int unsigned BRET_IDX = 30,
  parameter int unsigned XRET_IDX = 29
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic [31:0] insn_i,
  input  logic [31:0] pc_i,
  output logic        valid_o,
  output logic [4:0]  ra_idx_o,
  output logic [4:0]  rb_idx_o,
  output logic [4:0]  rd_idx_o,
  output logic        rd_we_o,
  output logic [4:0]  alu_op_o,
  output logic [31:0] imm_o,
  output logic        use_imm_o,
  output logic        mem_rd_o,
  output logic        mem_wr_o,
  output logic [1:0]  mem_size_o,
  output logic        mem_signed_o,
  output logic        mem_bypass_o,
  output logic [3:0]  flow_o,
  output logic [31:0] target_o,
  output logic [31:0] link_o,
  output logic [2:0]  exc_o
);
  logic [OP_W-1:0]   op, opx;
  logic [REG_AW-1:0] fa, fb, fc;
  logic [15:0]       imm16;
  logic [25:0]       imm26;
  logic [INSN_W-1:0] imm_c, tgt_c, link_c;
  logic              is_rtype;
  ctl_t              pri_ctl, ext_ctl, ctl;
  logic [REG_AW-1:0] rd_c, ra_c;

  rdec_fields u_fields (
    .insn_i(insn_i), .imm_sel_i(ctl.imm_sel), .op_o(op), .opx_o(opx),
    .a_o(fa), .b_o(fb), .c_o(fc), .imm16_o(imm16), .imm26_o(imm26), .imm_o(imm_c)
  );

  rdec_primary u_primary (.op_i(op), .rtype_o(is_rtype), .ctl_o(pri_ctl));
  rdec_ext     u_ext     (.opx_i(opx), .ctl_o(ext_ctl));

  assign ctl = is_rtype ? ext_ctl : pri_ctl;

  rdec_target u_target (
    .pc_i(pc_i), .imm16_i(imm16), .imm26_i(imm26), .tgt_i(ctl.tgt),
    .target_o(tgt_c), .link_o(link_c)
  );

  always_comb begin
    unique case (ctl.dst)
      DST_B:    rd_c = fb;
      DST_C:    rd_c = fc;
      DST_LINK: rd_c = REG_AW'(LINK_IDX);
      default:  rd_c = '0;
    endcase
    unique case (ctl.asel)
      ASEL_RA: ra_c = REG_AW'(LINK_IDX);
      ASEL_BA: ra_c = REG_AW'(BRET_IDX);
      ASEL_EA: ra_c = REG_AW'(XRET_IDX);
      default: ra_c = fa;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o      <= 1'b0;
      ra_idx_o     <= '0;
      rb_idx_o     <= '0;
      rd_idx_o     <= '0;
      rd_we_o      <= 1'b0;
      alu_op_o     <= '0;
      imm_o        <= '0;
      use_imm_o    <= 1'b0;
      mem_rd_o     <= 1'b0;
      mem_wr_o     <= 1'b0;
      mem_size_o   <= '0;
      mem_signed_o <= 1'b0;
      mem_bypass_o <= 1'b0;
      flow_o       <= '0;
      target_o     <= '0;
      link_o       <= '0;
      exc_o        <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        ra_idx_o     <= ra_c;
        rb_idx_o     <= fb;
        rd_idx_o     <= rd_c;
        rd_we_o      <= (ctl.dst != DST_NONE) && (rd_c != '0);
        alu_op_o     <= ctl.alu;
        imm_o        <= imm_c;
        use_imm_o    <= (ctl.imm_sel != IMM_NONE);
        mem_rd_o     <= ctl.mem_rd;
        mem_wr_o     <= ctl.mem_wr;
        mem_size_o   <= ctl.size;
        mem_signed_o <= ctl.msigned;
        mem_bypass_o <= ctl.bypass;
        flow_o       <= ctl.flow;
        target_o     <= tgt_c;
        link_o       <= link_c;
        exc_o        <= ctl.exc;
      end
    end
  end
endmodule

// File: rtl/rdec_checker.sv
module rdec_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [31:0] insn_i,
  input logic [31:0] pc_i,
  input logic        valid_o,
  input logic [4:0]  rd_idx_o,
  input logic        rd_we_o,
  input logic        mem_rd_o,
  input logic        mem_wr_o,
  input logic [3:0]  flow_o,
  input logic [31:0] target_o,
  input logic [2:0]  exc_o
);
  AST_CAPTURE_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && $stable(rd_idx_o) && $stable(target_o) && $stable(exc_o)); // R1
  AST_NO_R0_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_we_o |-> rd_idx_o != 5'd0); // R6
  AST_MEM_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_rd_o, mem_wr_o})); // R5
  AST_LOAD_R0_READS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && insn_i[5:0] == 6'h07 && insn_i[26:22] == 5'd0 |=> mem_rd_o && !rd_we_o); // R5
  AST_EXC_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o != 3'd0 |-> !rd_we_o && !mem_rd_o && !mem_wr_o && flow_o == 4'd0); // R10
  AST_ILLEGAL_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && insn_i[5:0] == 6'h02 |=> exc_o == 3'd1); // R10
  AST_ABS_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && insn_i[5:0] == 6'h01 |=>
      target_o == {$past(pc_i[31:28]), $past(insn_i[31:6]), 2'b00}); // R8
endmodule

bind risc_insn_decode rdec_checker u_rdec_checker (.*);

// File: tb/risc_insn_decode_bench.sv
`timescale 1ns/1ps
module risc_insn_decode_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic [31:0] pc_i = '0;
  logic        valid_o, rd_we_o, use_imm_o, mem_rd_o, mem_wr_o, mem_signed_o, mem_bypass_o;
  logic [4:0]  ra_idx_o, rb_idx_o, rd_idx_o, alu_op_o;
  logic [31:0] imm_o, target_o, link_o;
  logic [1:0]  mem_size_o;
  logic [3:0]  flow_o;
  logic [2:0]  exc_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk_i = ~clk_i;

  risc_insn_decode u_risc_insn_decode (.*);

  function automatic logic [31:0] it(logic [5:0] op, logic [4:0] a, logic [4:0] b, logic [15:0] i16);
    return {a, b, i16, op};
  endfunction
  function automatic logic [31:0] rt(logic [5:0] opx, logic [4:0] a, logic [4:0] b, logic [4:0] c, logic [4:0] i5);
    return {a, b, c, opx, i5, 6'h3A};
  endfunction
  function automatic logic [31:0] jt(logic [5:0] op, logic [25:0] i26);
    return {i26, op};
  endfunction

  typedef struct packed {
    logic [31:0] insn;
    logic [31:0] pc;
    logic [4:0]  rd;
    logic        we;
    logic [4:0]  alu;
    logic [31:0] imm;
    logic        mrd;
    logic        mwr;
    logic [1:0]  msz;
    logic        msg;
    logic [3:0]  fl;
    logic [31:0] tgt;
    logic [2:0]  exc;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VT [NV] = '{
    '{it(6'h04,3,5,16'hFFF0), 32'h100, 5'd5, 1'b1, 5'd1, 32'hFFFFFFF0, 1'b0,1'b0,2'd0,1'b0, 4'd0, 32'h0, 3'd0},
    '{it(6'h0C,2,7,16'h8001), 32'h100, 5'd7, 1'b1, 5'd4, 32'h00008001, 1'b0,1'b0,2'd0,1'b0, 4'd0, 32'h0, 3'd0},
    '{it(6'h34,1,9,16'h1234), 32'h100, 5'd9, 1'b1, 5'd5, 32'h12340000, 1'b0,1'b0,2'd0,1'b0, 4'd0, 32'h0, 3'd0},
    '{it(6'h07,4,0,16'h0004), 32'h100, 5'd0, 1'b0, 5'd1, 32'h00000004, 1'b1,1'b0,2'd0,1'b1, 4'd0, 32'h0, 3'd0},
    '{it(6'h2B,4,6,16'hFFFE), 32'h100, 5'd6, 1'b1, 5'd1, 32'hFFFFFFFE, 1'b1,1'b0,2'd1,1'b0, 4'd0, 32'h0, 3'd0},
    '{it(6'h15,8,9,16'h0010), 32'h100, 5'd0, 1'b0, 5'd1, 32'h00000010, 1'b0,1'b1,2'd2,1'b0, 4'd0, 32'h0, 3'd0},
    '{it(6'h26,1,2,16'hFFF3), 32'h1000, 5'd0, 1'b0, 5'd0, 32'h0, 1'b0,1'b0,2'd0,1'b0, 4'd2, 32'h00000FF4, 3'd0},
    '{it(6'h06,0,0,16'h0008), 32'h2000, 5'd0, 1'b0, 5'd0, 32'h0, 1'b0,1'b0,2'd0,1'b0, 4'd1, 32'h0000200C, 3'd0},
    '{jt(6'h01,26'h0123456), 32'hA0000010, 5'd0, 1'b0, 5'd0, 32'h0, 1'b0,1'b0,2'd0,1'b0, 4'd1, 32'hA048D158, 3'd0},
    '{jt(6'h00,26'h3FFFFFF), 32'h50000000, 5'd31, 1'b1, 5'd24, 32'h0, 1'b0,1'b0,2'd0,1'b0, 4'd1, 32'h5FFFFFFC, 3'd0},
    '{rt(6'h31,1,2,3,0), 32'h100, 5'd3, 1'b1, 5'd1, 32'h0, 1'b0,1'b0,2'd0,1'b0, 4'd0, 32'h0, 3'd0},
    '{rt(6'h39,1,2,0,0), 32'h100, 5'd0, 1'b0, 5'd2, 32'h0, 1'b0,1'b0,2'd0,1'b0, 4'd0, 32'h0, 3'd0},
    '{rt(6'h3A,1,0,4,7), 32'h100, 5'd4, 1'b1, 5'd10, 32'h7, 1'b0,1'b0,2'd0,1'b0, 4'd0, 32'h0, 3'd0},
    '{rt(6'h05,0,0,0,0), 32'h100, 5'd0, 1'b0, 5'd0, 32'h0, 1'b0,1'b0,2'd0,1'b0, 4'd8, 32'h0, 3'd0},
    '{rt(6'h1D,6,0,0,0), 32'h100, 5'd31, 1'b1, 5'd24, 32'h0, 1'b0,1'b0,2'd0,1'b0, 4'd8, 32'h0, 3'd0},
    '{rt(6'h2D,0,0,0,3), 32'h100, 5'd0, 1'b0, 5'd0, 32'h0, 1'b0,1'b0,2'd0,1'b0, 4'd0, 32'h0, 3'd3},
    '{rt(6'h34,0,0,0,0), 32'h100, 5'd0, 1'b0, 5'd0, 32'h0, 1'b0,1'b0,2'd0,1'b0, 4'd0, 32'h0, 3'd4},
    '{it(6'h02,1,2,16'h0000), 32'h100, 5'd0, 1'b0, 5'd0, 32'h0, 1'b0,1'b0,2'd0,1'b0, 4'd0, 32'h0, 3'd1},
    '{it(6'h32,1,2,16'h0000), 32'h100, 5'd0, 1'b0, 5'd0, 32'h0, 1'b0,1'b0,2'd0,1'b0, 4'd0, 32'h0, 3'd2},
    '{it(6'h38,1,2,16'h0000), 32'h100, 5'd0, 1'b0, 5'd0, 32'h0, 1'b0,1'b0,2'd0,1'b0, 4'd0, 32'h0, 3'd2},
    '{rt(6'h3C,1,2,3,0), 32'h100, 5'd0, 1'b0, 5'd0, 32'h0, 1'b0,1'b0,2'd0,1'b0, 4'd0, 32'h0, 3'd1},
    '{rt(6'h14,1,2,3,0), 32'h100, 5'd0, 1'b0, 5'd0, 32'h0, 1'b0,1'b0,2'd0,1'b0, 4'd0, 32'h0, 3'd2},
    '{rt(6'h00,1,2,3,0), 32'h100, 5'd0, 1'b0, 5'd0, 32'h0, 1'b0,1'b0,2'd0,1'b0, 4'd0, 32'h0, 3'd1},
    '{it(6'h13,1,2,16'h4444), 32'h100, 5'd0, 1'b0, 5'd0, 32'h0, 1'b0,1'b0,2'd0,1'b0, 4'd0, 32'h0, 3'd0},
    '{rt(6'h36,1,2,3,1), 32'h100, 5'd0, 1'b0, 5'd0, 32'h0, 1'b0,1'b0,2'd0,1'b0, 4'd0, 32'h0, 3'd0},
    '{it(6'h30,1,2,16'h8000), 32'h100, 5'd2, 1'b1, 5'd17, 32'h00008000, 1'b0,1'b0,2'd0,1'b0, 4'd0, 32'h0, 3'd0},
    '{it(6'h08,1,2,16'h8000), 32'h100, 5'd2, 1'b1, 5'd16, 32'hFFFF8000, 1'b0,1'b0,2'd0,1'b0, 4'd0, 32'h0, 3'd0},
    '{rt(6'h26,0,0,5,3), 32'h100, 5'd5, 1'b1, 5'd25, 32'h3, 1'b0,1'b0,2'd0,1'b0, 4'd0, 32'h0, 3'd0},
    '{rt(6'h2E,4,0,0,2), 32'h100, 5'd0, 1'b0, 5'd26, 32'h2, 1'b0,1'b0,2'd0,1'b0, 4'd0, 32'h0, 3'd0},
    '{rt(6'h1C,0,0,7,0), 32'h100, 5'd7, 1'b1, 5'd24, 32'h0, 1'b0,1'b0,2'd0,1'b0, 4'd0, 32'h0, 3'd0},
    '{it(6'h36,0,0,16'h7FFF), 32'h0, 5'd0, 1'b0, 5'd0, 32'h0, 1'b0,1'b0,2'd0,1'b0, 4'd6, 32'h00008000, 3'd0},
    '{rt(6'h01,0,0,0,0), 32'h100, 5'd0, 1'b0, 5'd0, 32'h0, 1'b0,1'b0,2'd0,1'b0, 4'd9, 32'h0, 3'd0}
  };
  localparam string VREQ [NV] = '{
    "R3", "R3", "R3", "R5", "R5", "R5", "R7", "R7", "R8", "R9", "R4", "R6", "R4",
    "R7", "R9", "R10", "R10", "R10", "R10", "R10", "R10", "R10", "R10", "R11", "R11",
    "R3", "R3", "R12", "R12", "R9", "R7", "R7"
  };

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] w, logic [31:0] pc);
    @(negedge clk_i);
    valid_i = 1'b1;
    insn_i  = w;
    pc_i    = pc;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1", "reset valid_o", 32'(valid_o), 32'd0);
    chk("R1", "reset rd_we_o", 32'(rd_we_o), 32'd0);
    chk("R1", "reset target_o", target_o, 32'd0);
    chk("R1", "reset exc_o", 32'(exc_o), 32'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      apply(VT[i].insn, VT[i].pc);
      chk(VREQ[i], $sformatf("v%0d valid", i), 32'(valid_o), 32'd1);
      chk(VREQ[i], $sformatf("v%0d rd_idx", i), 32'(rd_idx_o), 32'(VT[i].rd));
      chk(VREQ[i], $sformatf("v%0d rd_we", i), 32'(rd_we_o), 32'(VT[i].we));
      chk(VREQ[i], $sformatf("v%0d alu_op", i), 32'(alu_op_o), 32'(VT[i].alu));
      chk(VREQ[i], $sformatf("v%0d imm", i), imm_o, VT[i].imm);
      chk(VREQ[i], $sformatf("v%0d mem_rd", i), 32'(mem_rd_o), 32'(VT[i].mrd));
      chk(VREQ[i], $sformatf("v%0d mem_wr", i), 32'(mem_wr_o), 32'(VT[i].mwr));
      chk(VREQ[i], $sformatf("v%0d mem_size", i), 32'(mem_size_o), 32'(VT[i].msz));
      chk(VREQ[i], $sformatf("v%0d mem_signed", i), 32'(mem_signed_o), 32'(VT[i].msg));
      chk(VREQ[i], $sformatf("v%0d flow", i), 32'(flow_o), 32'(VT[i].fl));
      chk(VREQ[i], $sformatf("v%0d target", i), target_o, VT[i].tgt);
      chk(VREQ[i], $sformatf("v%0d exc", i), 32'(exc_o), 32'(VT[i].exc));
    end

    // R2: source indices and fixed return registers
    apply(rt(6'h31, 5'd1, 5'd2, 5'd3, 5'd0), 32'h100);
    chk("R2", "add ra_idx", 32'(ra_idx_o), 32'd1);
    chk("R2", "add rb_idx", 32'(rb_idx_o), 32'd2);
    chk("R3", "add use_imm", 32'(use_imm_o), 32'd0);
    apply(rt(6'h05, 5'd4, 5'd0, 5'd0, 5'd0), 32'h100);
    chk("R2", "ret ra_idx", 32'(ra_idx_o), 32'd31);
    apply(rt(6'h09, 5'd4, 5'd0, 5'd0, 5'd0), 32'h100);
    chk("R2", "bret ra_idx", 32'(ra_idx_o), 32'd30);
    apply(rt(6'h01, 5'd4, 5'd0, 5'd0, 5'd0), 32'h100);
    chk("R2", "xret ra_idx", 32'(ra_idx_o), 32'd29);
    // R5: bypass flag
    apply(it(6'h2B, 5'd1, 5'd2, 16'h0), 32'h100);
    chk("R5", "bypass load", 32'(mem_bypass_o), 32'd1);
    apply(it(6'h0B, 5'd1, 5'd2, 16'h0), 32'h100);
    chk("R5", "cached load", 32'(mem_bypass_o), 32'd0);
    // R9: link value
    apply(jt(6'h00, 26'h1), 32'h50000000);
    chk("R9", "call link", link_o, 32'h50000004);
    // R3: immediate use flag
    apply(it(6'h04, 5'd1, 5'd2, 16'h0001), 32'h100);
    chk("R3", "addi use_imm", 32'(use_imm_o), 32'd1);
    // R1: hold while idle with garbage on the inputs
    @(negedge clk_i);
    insn_i = it(6'h02, 5'd0, 5'd0, 16'h0);
    pc_i   = 32'hFFFF_FFF0;
    repeat (2) @(negedge clk_i);
    chk("R1", "idle valid_o", 32'(valid_o), 32'd0);
    chk("R1", "idle exc_o held", 32'(exc_o), 32'd0);
    chk("R1", "idle rd_idx held", 32'(rd_idx_o), 32'd2);
    chk("R1", "idle imm held", imm_o, 32'h1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule